// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block decides which operating mode a CAN FD protocol engine is in. After a system reset it sits in configuration mode. There the transmit line is forced recessive, and only in this mode does the bit-timing register accept writes. Software sets the core-enable bit and picks a target mode with three select bits. The block then waits until the sampled receive line has shown eleven recessive nominal bits in a row. At that point it moves to loopback, sleep, snoop or normal mode.

Clearing core-enable while the controller is operating returns it to configuration mode. On that entry the block pulses a clear to the error counters and error status. It also clears a fixed group of interrupt status bits and sets the configuration flag. Bus-off and protocol-exception faults lock the controller in a terminal state that only a system reset leaves.

The block also holds the sticky interrupt status register, its enable register and the combined interrupt line. Status bits are set by hardware pulses and cleared by writing ones. Frame timing, framing, arbitration and message storage sit elsewhere.

Top module: `can_mode_seq`

## Requirements
- R1: While `rstN` is low and right after it is released: `mode` is 0 (configuration), `irqStatus` is 12'h001 (only the configuration flag, bit 0), `irqEnable` is 0, `timingValue` is 0, `sysIrq` is 0 and both clear pulses are low.
- R2: In normal (1), snoop (2), sleep (3) or loopback (4) mode, a low `coreEnable` sampled at a clock edge puts `mode` at configuration (0) after that edge.
- R3: In an operating mode (1 to 4), `protoExcFault` moves `mode` to 6 and otherwise `busOffFault` moves it to 5, with priority over a low `coreEnable`. Modes 5 and 6 change only through `rstN`, whatever `coreEnable` does. In configuration mode both fault inputs are ignored.
- R4: `txForceRecessive` is 1 in modes 0, 5 and 6 and 0 in modes 1 to 4.
- R5: In the first cycle of configuration mode after leaving an operating mode, `errClearPulse` is 1 and `irqClearPulse` is 12'h3FE, each for that one cycle only, and status bit 0 is set.
- R6: That entry clears status bits 1 to 9 (arbitration lost, TX done, RX done, RX overflow 0 and 1, error, bus-off, sleep, wakeup) and keeps bits 10 (TX request pending) and 11 (TX cancel served).
- R7: With `coreEnable` high in configuration mode, the mode changes at the clock edge of the 11th consecutive `bitStrobe` with `rxBit` = 1. A strobe with `rxBit` = 0, or a cycle with `coreEnable` low, restarts the count from zero.
- R8: The exit target is taken from the select inputs at the exit edge, in priority order: loopback (4), then sleep (3), then snoop (2), and normal (1) if none is set.
- R9: Changes to the select inputs while in an operating mode do not change `mode`.
- R10: `sysIrq` is 1 exactly when some bit is 1 in both `irqStatus` and `irqEnable`. `irqEnable` is loaded from `irqEnData` when `irqEnWe` is high.
- R11: Status bits are sticky. A bit is cleared when `irqClrWe` is high and the same bit of `irqClrData` is 1. A `hwIrqSet` bit in the same cycle takes precedence over that clear and over the entry clear.
- R12: A write with `timingWe` loads `timingValue` only when `mode` is 0. In every other mode the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low system reset |
| coreEnable | input | 1 | Core enable bit |
| selSnoop | input | 1 | Snoop mode select |
| selSleep | input | 1 | Sleep mode select |
| selLoopback | input | 1 | Loopback mode select |
| rxBit | input | 1 | Sampled receive bit, 1 = recessive |
| bitStrobe | input | 1 | Nominal bit-time sample strobe |
| busOffFault | input | 1 | Bus-off condition from protocol engine |
| protoExcFault | input | 1 | Protocol exception from protocol engine |
| hwIrqSet | input | 12 | Hardware set pulses for status bits |
| irqClrWe | input | 1 | Status clear write strobe |
| irqClrData | input | 12 | Write-one-to-clear mask |
| irqEnWe | input | 1 | Enable register write strobe |
| irqEnData | input | 12 | Enable register write data |
| timingWe | input | 1 | Bit-timing register write strobe |
| timingData | input | TIMING_W | Bit-timing register write data |
| mode | output | 3 | Current mode code |
| txForceRecessive | output | 1 | Forces transmit line recessive |
| errClearPulse | output | 1 | Clear for error counters and error status |
| irqClearPulse | output | 12 | Status bits cleared on configuration entry |
| configFlag | output | 1 | Configuration flag (status bit 0) |
| irqStatus | output | 12 | Interrupt status register |
| irqEnable | output | 12 | Interrupt enable register |
| timingValue | output | TIMING_W | Bit-timing register contents |
| sysIrq | output | 1 | Combined interrupt output |

## Verification
Three things can land on the same status register edge: the clear group fired by entering configuration mode, a software write-one-to-clear, and a hardware set pulse. The bench lines up a hardware set with a clear write. It also lines up a hardware set with the edge where a low enable drops the controller into configuration mode. In both cases it compares the status word one cycle later against the rule that a set wins over either clear. It also drives bus-off and protocol exception in the same cycle as a low enable, and judges that the protocol-exception state wins.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [2:0] {
    MODE_CONFIG   = 3'd0,
    MODE_NORMAL   = 3'd1,
    MODE_SNOOP    = 3'd2,
    MODE_SLEEP    = 3'd3,
    MODE_LOOPBACK = 3'd4,
    MODE_BUSOFF   = 3'd5,
    MODE_PROTEXC  = 3'd6
  } modeT;

  localparam int IRQ_W = 12;
  localparam int IRQ_CFG_BIT = 0;
  // bits 1..9 are wiped when configuration mode is entered, 10..11 survive
  localparam logic [IRQ_W-1:0] ENTRY_CLR_MASK = 12'h3FE;

  typedef struct packed {
    logic cfgEntry;     // leaving an operating mode this edge
    logic timingAllow;  // bit-timing writes accepted
  } strobeT;

  function automatic modeT pickTarget(input logic lb, input logic sl, input logic sn);
    if (lb) return MODE_LOOPBACK;
    if (sl) return MODE_SLEEP;
    if (sn) return MODE_SNOOP;
    return MODE_NORMAL;
  endfunction
endpackage

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int RECESSIVE_BITS = 11
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   coreEnable,
  input  logic   selSnoop,
  input  logic   selSleep,
  input  logic   selLoopback,
  input  logic   rxBit,
  input  logic   bitStrobe,
  input  logic   busOffFault,
  input  logic   protoExcFault,
  output modeT   mode,
  output strobeT strobes
);
  localparam int CNT_W = $clog2(RECESSIVE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RECESSIVE_BITS - 1);

  modeT modeNext;
  logic [CNT_W-1:0] recCnt, recCntNext;
  logic cfgEntry;

  always_comb begin
    modeNext   = mode;
    recCntNext = recCnt;
    cfgEntry   = 1'b0;
    unique case (mode)
      MODE_CONFIG: begin
        if (!coreEnable) begin
          recCntNext = '0;
        end else if (bitStrobe) begin
          if (!rxBit) begin
            recCntNext = '0;
          end else if (recCnt == LAST_CNT) begin
            recCntNext = '0;
            modeNext   = pickTarget(selLoopback, selSleep, selSnoop);
          end else begin
            recCntNext = recCnt + 1'b1;
          end
        end
      end
      MODE_BUSOFF, MODE_PROTEXC: ;
      default: begin
        if (protoExcFault)      modeNext = MODE_PROTEXC;
        else if (busOffFault)   modeNext = MODE_BUSOFF;
        else if (!coreEnable) begin
          modeNext = MODE_CONFIG;
          cfgEntry = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode   <= MODE_CONFIG;
      recCnt <= '0;
    end else begin
      mode   <= modeNext;
      recCnt <= recCntNext;
    end
  end

  assign strobes.cfgEntry    = cfgEntry;
  assign strobes.timingAllow = (mode == MODE_CONFIG);
endmodule

// File: rtl/can_mode_dp.sv
module can_mode_dp
  import can_mode_pkg::*;
#(
  parameter int TIMING_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobes,
  input  logic [IRQ_W-1:0]    hwIrqSet,
  input  logic                irqClrWe,
  input  logic [IRQ_W-1:0]    irqClrData,
  input  logic                irqEnWe,
  input  logic [IRQ_W-1:0]    irqEnData,
  input  logic                timingWe,
  input  logic [TIMING_W-1:0] timingData,
  output logic                errClearPulse,
  output logic [IRQ_W-1:0]    irqClearPulse,
  output logic [IRQ_W-1:0]    irqStatus,
  output logic [IRQ_W-1:0]    irqEnable,
  output logic [TIMING_W-1:0] timingValue,
  output logic                sysIrq
);
  localparam logic [IRQ_W-1:0] CFG_ONEHOT = IRQ_W'(1) << IRQ_CFG_BIT;

  logic [IRQ_W-1:0] clrMask, setMask, statusNext;

  always_comb begin
    clrMask = irqClrWe ? irqClrData : '0;
    setMask = hwIrqSet;
    if (strobes.cfgEntry) begin
      clrMask = clrMask | ENTRY_CLR_MASK;
      setMask = setMask | CFG_ONEHOT;
    end
    statusNext = (irqStatus & ~clrMask) | setMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqStatus     <= CFG_ONEHOT;
      irqEnable     <= '0;
      timingValue   <= '0;
      errClearPulse <= 1'b0;
      irqClearPulse <= '0;
    end else begin
      irqStatus     <= statusNext;
      errClearPulse <= strobes.cfgEntry;
      irqClearPulse <= strobes.cfgEntry ? ENTRY_CLR_MASK : '0;
      if (irqEnWe) irqEnable <= irqEnData;
      if (timingWe && strobes.timingAllow) timingValue <= timingData;
    end
  end

  assign sysIrq = |(irqStatus & irqEnable);
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int TIMING_W       = 16,
  parameter int RECESSIVE_BITS = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                coreEnable,
  input  logic                selSnoop,
  input  logic                selSleep,
  input  logic                selLoopback,
  input  logic                rxBit,
  input  logic                bitStrobe,
  input  logic                busOffFault,
  input  logic                protoExcFault,
  input  logic [11:0]         hwIrqSet,
  input  logic                irqClrWe,
  input  logic [11:0]         irqClrData,
  input  logic                irqEnWe,
  input  logic [11:0]         irqEnData,
  input  logic                timingWe,
  input  logic [TIMING_W-1:0] timingData,
  output logic [2:0]          mode,
  output logic                txForceRecessive,
  output logic                errClearPulse,
  output logic [11:0]         irqClearPulse,
  output logic                configFlag,
  output logic [11:0]         irqStatus,
  output logic [11:0]         irqEnable,
  output logic [TIMING_W-1:0] timingValue,
  output logic                sysIrq
);
  modeT   curMode;
  strobeT strobes;

  can_mode_ctrl #(.RECESSIVE_BITS(RECESSIVE_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .coreEnable(coreEnable),
    .selSnoop(selSnoop), .selSleep(selSleep), .selLoopback(selLoopback),
    .rxBit(rxBit), .bitStrobe(bitStrobe),
    .busOffFault(busOffFault), .protoExcFault(protoExcFault),
    .mode(curMode), .strobes(strobes)
  );

  can_mode_dp #(.TIMING_W(TIMING_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .hwIrqSet(hwIrqSet), .irqClrWe(irqClrWe), .irqClrData(irqClrData),
    .irqEnWe(irqEnWe), .irqEnData(irqEnData),
    .timingWe(timingWe), .timingData(timingData),
    .errClearPulse(errClearPulse), .irqClearPulse(irqClearPulse),
    .irqStatus(irqStatus), .irqEnable(irqEnable),
    .timingValue(timingValue), .sysIrq(sysIrq)
  );

  assign mode             = curMode;
  assign txForceRecessive = (curMode == MODE_CONFIG) || (curMode == MODE_BUSOFF)
                            || (curMode == MODE_PROTEXC);
  assign configFlag       = irqStatus[IRQ_CFG_BIT];
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk #(
  parameter int TIMING_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                coreEnable,
  input logic                selLoopback,
  input logic [2:0]          mode,
  input logic                txForceRecessive,
  input logic                errClearPulse,
  input logic                configFlag,
  input logic [TIMING_W-1:0] timingValue
);
  AST_CONFIG_TX_RECESSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd0) |-> txForceRecessive); // R4

  AST_BUSOFF_TERMINAL: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd5) |=> (mode == 3'd5)); // R3

  AST_PROTEXC_TERMINAL: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'd6) |=> (mode == 3'd6)); // R3

  AST_ENTRY_PULSES: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 3'd0) && ($past(mode) != 3'd0)) |-> (errClearPulse && configFlag)); // R5

  AST_EXIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (($past(mode) == 3'd0) && (mode != 3'd0)) |-> $past(coreEnable)); // R7

  AST_LOOPBACK_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (($past(mode) == 3'd0) && (mode != 3'd0) && $past(selLoopback)) |-> (mode == 3'd4)); // R8

  AST_TIMING_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 3'd0) |=> $stable(timingValue)); // R12
endmodule

bind can_mode_seq can_mode_seq_chk #(.TIMING_W(TIMING_W)) uChk (
  .clk(clk), .rstN(rstN), .coreEnable(coreEnable), .selLoopback(selLoopback),
  .mode(mode), .txForceRecessive(txForceRecessive), .errClearPulse(errClearPulse),
  .configFlag(configFlag), .timingValue(timingValue)
);

// File: tb/can_mode_seq_test.sv
module can_mode_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coreEnable = 0, selSnoop = 0, selSleep = 0, selLoopback = 0;
  logic rxBit = 1, bitStrobe = 0, busOffFault = 0, protoExcFault = 0;
  logic [11:0] hwIrqSet = '0, irqClrData = '0, irqEnData = '0;
  logic irqClrWe = 0, irqEnWe = 0, timingWe = 0;
  logic [TW-1:0] timingData = '0;
  logic [2:0] mode;
  logic txForceRecessive, errClearPulse, configFlag, sysIrq;
  logic [11:0] irqClearPulse, irqStatus, irqEnable;
  logic [TW-1:0] timingValue;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mode_seq #(.TIMING_W(TW)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 0; coreEnable = 0; selSnoop = 0; selSleep = 0; selLoopback = 0;
    rxBit = 1; bitStrobe = 0; busOffFault = 0; protoExcFault = 0;
    hwIrqSet = '0; irqClrWe = 0; irqEnWe = 0; timingWe = 0;
    cyc(3);
    rstN = 1;
    cyc(1);
  endtask

  task automatic strobe(input logic b);
    rxBit = b; bitStrobe = 1;
    cyc(1);
    bitStrobe = 0; rxBit = 1;
  endtask

  task automatic recessiveRun(input int n);
    for (int i = 0; i < n; i++) strobe(1'b1);
  endtask

  task automatic goOperating(input logic lb, input logic sl, input logic sn);
    selLoopback = lb; selSleep = sl; selSnoop = sn; coreEnable = 1;
    recessiveRun(11);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 mode", mode, 0);
    chk("R1 status", irqStatus, 12'h001);
    chk("R1 enable", irqEnable, 0);
    chk("R1 timing", timingValue, 0);
    chk("R1 sysIrq", sysIrq, 0);
    chk("R1 errClear", errClearPulse, 0);
    chk("R1 irqClear", irqClearPulse, 0);
    chk("R4 tx in config", txForceRecessive, 1);
  endtask

  task automatic testExitCount();
    doReset();
    selLoopback = 0; selSleep = 0; selSnoop = 0; coreEnable = 1;
    recessiveRun(10);
    chk("R7 ten recessive", mode, 0);
    strobe(1'b1);
    chk("R7 eleventh", mode, 1);
    chk("R8 normal", mode, 1);
    chk("R4 tx normal", txForceRecessive, 0);
    // dominant restart
    coreEnable = 0; cyc(1);
    chk("R2 disable", mode, 0);
    coreEnable = 1;
    recessiveRun(6); strobe(1'b0); recessiveRun(10);
    chk("R7 dominant restart", mode, 0);
    strobe(1'b1);
    chk("R7 after restart", mode, 1);
    // disable restart
    coreEnable = 0; cyc(1);
    coreEnable = 1;
    recessiveRun(5);
    coreEnable = 0; cyc(1); coreEnable = 1;
    recessiveRun(10);
    chk("R7 enable drop restart", mode, 0);
    strobe(1'b1);
    chk("R7 after enable restart", mode, 1);
  endtask

  task automatic testPriority();
    doReset();
    goOperating(1, 1, 1);
    chk("R8 loopback", mode, 4);
    coreEnable = 0; cyc(1);
    goOperating(0, 1, 1);
    chk("R8 sleep", mode, 3);
    coreEnable = 0; cyc(1);
    goOperating(0, 0, 1);
    chk("R8 snoop", mode, 2);
    selLoopback = 1; selSleep = 1; cyc(3);
    chk("R9 select ignored", mode, 2);
    chk("R4 tx snoop", txForceRecessive, 0);
  endtask

  task automatic testEntryClear();
    doReset();
    goOperating(0, 0, 0);
    hwIrqSet = 12'hFFE; cyc(1); hwIrqSet = '0;
    chk("R11 hw set", irqStatus, 12'hFFF);
    coreEnable = 0; cyc(1);
    chk("R5 errClear", errClearPulse, 1);
    chk("R5 irqClear", irqClearPulse, 12'h3FE);
    chk("R6 kept bits", irqStatus, 12'hC01);
    chk("R5 configFlag", configFlag, 1);
    cyc(1);
    chk("R5 errClear one cycle", errClearPulse, 0);
    chk("R5 irqClear one cycle", irqClearPulse, 0);
    // hw set concurrent with entry
    goOperating(0, 0, 0);
    coreEnable = 0; hwIrqSet = 12'h008; cyc(1); hwIrqSet = '0;
    chk("R11 set beats entry clear", irqStatus, 12'hC09);
  endtask

  task automatic testIrqRegs();
    doReset();
    hwIrqSet = 12'h004; cyc(1); hwIrqSet = '0;
    chk("R11 sticky", irqStatus, 12'h005);
    cyc(2);
    chk("R11 still set", irqStatus, 12'h005);
    irqEnWe = 1; irqEnData = 12'h002; cyc(1); irqEnWe = 0;
    chk("R10 enable load", irqEnable, 12'h002);
    chk("R10 no match", sysIrq, 0);
    irqEnWe = 1; irqEnData = 12'h004; cyc(1); irqEnWe = 0;
    chk("R10 match", sysIrq, 1);
    irqClrWe = 1; irqClrData = 12'h005; hwIrqSet = 12'h004; cyc(1);
    irqClrWe = 0; hwIrqSet = '0;
    chk("R11 set beats clear", irqStatus, 12'h004);
    irqClrWe = 1; irqClrData = 12'h004; cyc(1); irqClrWe = 0;
    chk("R11 w1c", irqStatus, 12'h000);
    chk("R10 low after clear", sysIrq, 0);
  endtask

  task automatic testFaults();
    doReset();
    busOffFault = 1; cyc(2); busOffFault = 0;
    chk("R3 fault ignored in config", mode, 0);
    goOperating(0, 0, 0);
    busOffFault = 1; cyc(1); busOffFault = 0;
    chk("R3 bus-off", mode, 5);
    chk("R4 tx bus-off", txForceRecessive, 1);
    coreEnable = 0; cyc(2); coreEnable = 1; recessiveRun(12);
    chk("R3 enable no effect", mode, 5);
    doReset();
    chk("R3 reset exits", mode, 0);
    goOperating(0, 0, 0);
    protoExcFault = 1; busOffFault = 1; coreEnable = 0; cyc(1);
    protoExcFault = 0; busOffFault = 0;
    chk("R3 protocol exception wins", mode, 6);
    chk("R4 tx protexc", txForceRecessive, 1);
    coreEnable = 1; recessiveRun(11);
    chk("R3 protexc sticky", mode, 6);
  endtask

  task automatic testTiming();
    doReset();
    timingWe = 1; timingData = 16'h1234; cyc(1); timingWe = 0;
    chk("R12 config write", timingValue, 16'h1234);
    goOperating(0, 0, 0);
    timingWe = 1; timingData = 16'hABCD; cyc(1); timingWe = 0;
    chk("R12 normal write ignored", timingValue, 16'h1234);
  endtask

  initial begin
    cyc(1);
    testReset();
    testExitCount();
    testPriority();
    testEntryClear();
    testIrqRegs();
    testFaults();
    testTiming();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule